// File: doc/BRIEF.md
# Indexed Address/Data Register Memory Transfer Unit

This block moves words between a small internal synchronous memory and six registers. Three of the registers hold addresses: a program counter, a memory address register and an I/O address register. Three hold data: an instruction register, a data register and a buffer. A 2-bit address index picks which address register drives the memory address bus. A separate 2-bit data index picks which data register sends or receives the word. The two indices are independent, so any address register can be paired with any data register.

A command is presented with `cmd_valid` and a 2-bit opcode. The opcodes are read, write, load of an address register and load of a data register. Loads take their value from `load_val`. A write commits on the edge where the command is sampled. A read uses a registered memory output, so the data register is updated one edge later. During that extra cycle `busy` is high and any new command is dropped. An index of 3 in a field the opcode uses is illegal: the command is dropped and `err` pulses.

Top module: `memxfer`

## Requirements
- R1: After reset all six registers read 0, and `busy` and `err` are 0.
- R2: Opcode 2'b10 (load address) with `idx_a` = 0, 1 or 2 writes `load_val` into the program counter, memory address or I/O address register respectively on the sampling edge. No other register changes.
- R3: Opcode 2'b11 (load data) with `idx_d` = 0, 1 or 2 writes `load_val` into the instruction, data or buffer register respectively on the sampling edge. No other register changes.
- R4: Opcode 2'b01 (write) stores data register `idx_d` into the memory word addressed by address register `idx_a`. It commits on the sampling edge.
- R5: Opcode 2'b00 (read) loads the memory word addressed by address register `idx_a` into data register `idx_d` on the second edge after the command. In the cycle between those two edges the target still holds its old value.
- R6: `busy` is high for exactly the one cycle after an accepted read and is low at all other times.
- R7: A command presented while `busy` is high is ignored: no register or memory word changes, and `err` stays low.
- R8: An index value of 3 in a field the opcode uses makes the command ignored, and `err` is high for exactly the following cycle. Both fields are used by read and write. Only `idx_a` is used by load address, and only `idx_d` by load data. A 3 in the field the opcode does not use has no effect.
- R9: Only the low AW bits of the selected address register form the memory address. Higher bits are ignored.
- R10: `mem_addr` shows, combinationally, the low AW bits of the address register chosen by `idx_a`. It shows 0 when `idx_a` is 3.
- R11: Any address register can pair with any data register in reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 write, 10 load address, 11 load data |
| idx_a | input | 2 | Address register index (0 PC, 1 MAR, 2 I/O) |
| idx_d | input | 2 | Data register index (0 IR, 1 DR, 2 BUF) |
| load_val | input | DW | Value for load commands |
| busy | output | 1 | Read completing; commands dropped |
| err | output | 1 | Pulse after an illegal-index command |
| mem_addr | output | AW | Memory address bus |
| areg_pc | output | DW | Program counter |
| areg_mar | output | DW | Memory address register |
| areg_io | output | DW | I/O address register |
| dreg_ir | output | DW | Instruction register |
| dreg_dr | output | DW | Data register |
| dreg_buf | output | DW | Buffer register |

## Verification
The bench uses the defaults DW=8 and AW=4, so address registers are wider than the memory address. That lets two registers alias the same word (0x15 and 0x05 both reach word 5), which exposes R9. The 16-word memory is small enough that directed writes to a few words followed by cross-paired reads cover every address/data pairing that matters. The bench also issues back-to-back commands to hit the single busy cycle, and it places illegal indices in both the used and the unused field.

// File: rtl/memxfer.sv
module memxfer #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    idx_a,
  input  logic [1:0]    idx_d,
  input  logic [DW-1:0] load_val,
  output logic          busy,
  output logic          err,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] areg_pc,
  output logic [DW-1:0] areg_mar,
  output logic [DW-1:0] areg_io,
  output logic [DW-1:0] dreg_ir,
  output logic [DW-1:0] dreg_dr,
  output logic [DW-1:0] dreg_buf
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_LA = 2'd2;
  localparam logic [1:0] OP_LD = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [1:0]    pend_j;
  logic          busy_q, err_q;
  logic [DW-1:0] a_sel, d_sel;
  logic          bad;

  always_comb begin
    case (idx_a)
      2'd0:    a_sel = areg_pc;
      2'd1:    a_sel = areg_mar;
      2'd2:    a_sel = areg_io;
      default: a_sel = '0;
    endcase
    case (idx_d)
      2'd0:    d_sel = dreg_ir;
      2'd1:    d_sel = dreg_dr;
      2'd2:    d_sel = dreg_buf;
      default: d_sel = '0;
    endcase
  end

  wire a_bad = (idx_a == 2'd3);
  wire d_bad = (idx_d == 2'd3);

  always_comb begin
    case (cmd_op)
      OP_LA:   bad = a_bad;
      OP_LD:   bad = d_bad;
      default: bad = a_bad | d_bad;
    endcase
  end

  wire acc   = cmd_valid & ~busy_q;
  wire go    = acc & ~bad;
  wire go_rd = go & (cmd_op == OP_RD);
  wire go_wr = go & (cmd_op == OP_WR);
  wire go_la = go & (cmd_op == OP_LA);
  wire go_ld = go & (cmd_op == OP_LD);

  assign mem_addr = a_sel[AW-1:0];
  assign busy     = busy_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (go_wr) mem[mem_addr] <= d_sel;
    if (go_rd) rd_q <= mem[mem_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      pend_j   <= 2'd0;
      areg_pc  <= '0;
      areg_mar <= '0;
      areg_io  <= '0;
      dreg_ir  <= '0;
      dreg_dr  <= '0;
      dreg_buf <= '0;
    end else begin
      busy_q <= go_rd;
      err_q  <= acc & bad;
      if (go_rd) pend_j <= idx_d;
      if (go_la) begin
        case (idx_a)
          2'd0:    areg_pc  <= load_val;
          2'd1:    areg_mar <= load_val;
          2'd2:    areg_io  <= load_val;
          default: ;
        endcase
      end
      if (go_ld) begin
        case (idx_d)
          2'd0:    dreg_ir  <= load_val;
          2'd1:    dreg_dr  <= load_val;
          2'd2:    dreg_buf <= load_val;
          default: ;
        endcase
      end
      if (busy_q) begin
        case (pend_j)
          2'd0:    dreg_ir  <= rd_q;
          2'd1:    dreg_dr  <= rd_q;
          2'd2:    dreg_buf <= rd_q;
          default: ;
        endcase
      end
    end
  end
endmodule

module memxfer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [1:0]    idx_a,
  input logic [1:0]    idx_d,
  input logic          busy,
  input logic          err,
  input logic [1:0]    pend_j,
  input logic [DW-1:0] rd_q,
  input logic [DW-1:0] areg_pc,
  input logic [DW-1:0] areg_mar,
  input logic [DW-1:0] areg_io,
  input logic [DW-1:0] dreg_ir,
  input logic [DW-1:0] dreg_dr,
  input logic [DW-1:0] dreg_buf
);
  wire ill = (cmd_op == 2'd2) ? (idx_a == 2'd3) :
             (cmd_op == 2'd3) ? (idx_d == 2'd3) :
             ((idx_a == 2'd3) || (idx_d == 2'd3));

  a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r6_read_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd0 && !ill) |=> busy);

  a_r8_err_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && ill) |=> (err && !busy));

  a_r7_no_err_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !err);

  a_r7_addr_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(areg_pc) && $stable(areg_mar) && $stable(areg_io)));

  a_r5_read_lands_ir: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend_j == 2'd0) |=> (dreg_ir == $past(rd_q)));

  a_r5_read_lands_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend_j == 2'd2) |=> (dreg_buf == $past(rd_q) && $stable(dreg_ir)));
endmodule

bind memxfer memxfer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .idx_a(idx_a), .idx_d(idx_d), .busy(busy), .err(err),
  .pend_j(pend_j), .rd_q(rd_q),
  .areg_pc(areg_pc), .areg_mar(areg_mar), .areg_io(areg_io),
  .dreg_ir(dreg_ir), .dreg_dr(dreg_dr), .dreg_buf(dreg_buf)
);

// File: tb/tb_memxfer.sv
`timescale 1ns/100ps
module tb_memxfer;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [1:0]    idx_a = 2'd0;
  logic [1:0]    idx_d = 2'd0;
  logic [DW-1:0] load_val = '0;
  logic          busy, err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] areg_pc, areg_mar, areg_io, dreg_ir, dreg_dr, dreg_buf;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  memxfer #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .idx_a(idx_a), .idx_d(idx_d), .load_val(load_val),
    .busy(busy), .err(err), .mem_addr(mem_addr),
    .areg_pc(areg_pc), .areg_mar(areg_mar), .areg_io(areg_io),
    .dreg_ir(dreg_ir), .dreg_dr(dreg_dr), .dreg_buf(dreg_buf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; returns at the falling edge after the sampling edge.
  task automatic do_cmd(input logic [1:0] op, input logic [1:0] ia,
                        input logic [1:0] id, input logic [DW-1:0] v);
    cmd_valid = 1'b1; cmd_op = op; idx_a = ia; idx_d = id; load_val = v;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pc", areg_pc, 0);  chk("R1 mar", areg_mar, 0); chk("R1 io", areg_io, 0);
    chk("R1 ir", dreg_ir, 0);  chk("R1 dr", dreg_dr, 0);   chk("R1 buf", dreg_buf, 0);
    chk("R1 busy", busy, 0);   chk("R1 err", err, 0);
  endtask

  task automatic t_loads();
    do_cmd(2'd2, 2'd0, 2'd3, 8'h05);
    chk("R2 pc", areg_pc, 8'h05); chk("R2 mar untouched", areg_mar, 0);
    chk("R8 unused idx_d=3 no err", err, 0);
    do_cmd(2'd2, 2'd1, 2'd0, 8'h15);
    do_cmd(2'd2, 2'd2, 2'd0, 8'h0A);
    chk("R2 mar", areg_mar, 8'h15); chk("R2 io", areg_io, 8'h0A); chk("R2 pc kept", areg_pc, 8'h05);
    do_cmd(2'd3, 2'd3, 2'd0, 8'h11);
    chk("R3 ir", dreg_ir, 8'h11); chk("R8 unused idx_a=3 no err", err, 0);
    do_cmd(2'd3, 2'd0, 2'd1, 8'h22);
    do_cmd(2'd3, 2'd0, 2'd2, 8'h33);
    chk("R3 dr", dreg_dr, 8'h22); chk("R3 buf", dreg_buf, 8'h33); chk("R3 ir kept", dreg_ir, 8'h11);
    chk("R2 addr regs kept", {areg_pc, areg_mar, areg_io}, {8'h05, 8'h15, 8'h0A});
  endtask

  task automatic t_addr_bus();
    idx_a = 2'd0; #1 chk("R10 pc bus", mem_addr, 4'h5);
    idx_a = 2'd1; #1 chk("R10 R9 mar bus low bits", mem_addr, 4'h5);
    idx_a = 2'd2; #1 chk("R10 io bus", mem_addr, 4'hA);
    idx_a = 2'd3; #1 chk("R10 idx 3 bus", mem_addr, 4'h0);
    @(negedge clk);
  endtask

  task automatic t_write_read();
    do_cmd(2'd1, 2'd0, 2'd1, 8'h00);       // M[5] <= DR (22)
    do_cmd(2'd1, 2'd2, 2'd2, 8'h00);       // M[A] <= BUF (33)
    chk("R4 write no busy", busy, 0);
    do_cmd(2'd0, 2'd1, 2'd0, 8'h00);       // IR <= M[MAR low = 5]
    chk("R6 busy after read", busy, 1);
    chk("R5 ir old in busy cycle", dreg_ir, 8'h11);
    idle();
    chk("R5 R9 R11 ir loaded", dreg_ir, 8'h22);
    chk("R6 busy drops", busy, 0);
    do_cmd(2'd0, 2'd2, 2'd1, 8'h00);       // DR <= M[A]
    idle();
    chk("R4 R11 dr from io word", dreg_dr, 8'h33);
  endtask

  task automatic t_blocked();
    do_cmd(2'd0, 2'd0, 2'd2, 8'h00);       // BUF <= M[5] = 22
    do_cmd(2'd3, 2'd0, 2'd0, 8'hEE);       // blocked load IR
    chk("R7 buf read done", dreg_buf, 8'h22);
    chk("R7 ir unchanged", dreg_ir, 8'h22);
    chk("R7 no err", err, 0);
    do_cmd(2'd0, 2'd2, 2'd0, 8'h00);       // IR <= M[A] = 33
    do_cmd(2'd1, 2'd0, 2'd1, 8'h00);       // blocked write M[5] <= DR (33)
    do_cmd(2'd2, 2'd0, 2'd0, 8'h7F);
    chk("R7 pc load after busy accepted", areg_pc, 8'h7F);
    do_cmd(2'd2, 2'd0, 2'd0, 8'h05);
    do_cmd(2'd0, 2'd0, 2'd2, 8'h00);       // BUF <= M[5]
    idle();
    chk("R7 memory kept", dreg_buf, 8'h22);
    chk("R5 ir from io word", dreg_ir, 8'h33);
  endtask

  task automatic t_illegal();
    do_cmd(2'd2, 2'd3, 2'd0, 8'h77);
    chk("R8 err load addr", err, 1);
    chk("R8 addr regs kept", {areg_pc, areg_mar, areg_io}, {8'h05, 8'h15, 8'h0A});
    idle();
    chk("R8 err one cycle", err, 0);
    do_cmd(2'd1, 2'd0, 2'd3, 8'h00);       // illegal write to M[5]
    chk("R8 err write", err, 1);
    do_cmd(2'd0, 2'd3, 2'd0, 8'h00);       // illegal read
    chk("R8 illegal read no busy", busy, 0);
    chk("R8 err read", err, 1);
    do_cmd(2'd3, 2'd0, 2'd3, 8'h99);
    chk("R8 err load data", err, 1);
    chk("R8 data regs kept", {dreg_ir, dreg_dr, dreg_buf}, {8'h33, 8'h33, 8'h22});
    do_cmd(2'd0, 2'd0, 2'd1, 8'h00);       // DR <= M[5]
    idle();
    chk("R8 memory kept after illegal write", dreg_dr, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loads();
    t_addr_bus();
    t_write_read();
    t_blocked();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule